// File: doc/BRIEF.md
# Printer Port Register Interface

This block is the byte-wide register file of a legacy printer port, attached to a simple host bus with single-cycle read and write strobes and a small address field. It holds an output data latch, an input data latch, a status register and a control register. A control write that raises the strobe bit emits the output latch on an 8-bit byte port, with a one-clock "byte sent" pulse. An interrupt request line reports a pending interrupt.

The peripheral's busy/acknowledge handshake is modelled inside the register file, so no printer model is needed. Releasing the strobe with interrupts enabled arms the interrupt. Each status read clears any pending interrupt and steps the acknowledge and busy bits through their sequence. An external input port loads the input latch, and a data read returns that latch when the direction bit selects input.

Top module: `prn_port_regs`

## Requirements
- R1: After reset, a data read returns 0xFF, a status read returns 0xD9, a control read returns 0xCC and `irq` is 0.
- R2: Offset 0 is data, offset 1 is status and offset 2 is control. A read of any other offset returns 0xFF. Writes to offset 1 or to offsets 3 and above change no register.
- R3: A control write stores the written byte with bits 7 and 6 forced to 1, and a control read returns the stored value.
- R4: A control write with bit 2 (INIT, active low) at 0 loads status with 0xD8 (BUSY-complement bit 7, ACK bit 6, ONLINE bit 4 and ERROR-complement bit 3 all set, timeout bit 0 clear).
- R5: A control write with bit 2 at 1, bit 3 (SELECT) at 1 and bit 0 (STROBE) at 1 clears status bit 7. If the stored STROBE bit was 0 before the write, `byte_sent` is high for exactly the following clock and `byte_out` carries the output latch value held at the time of the write. With the stored STROBE already 1, no byte is sent.
- R6: A control write with bit 2 at 1, bit 3 at 1 and bit 0 at 0 sets the pending interrupt if the previously stored bit 4 (interrupt enable) was 1, and `irq` is high from the next clock.
- R7: A status read returns the status value held before the read and clears the pending interrupt, so `irq` is 0 from the next clock.
- R8: After a status read, if status bit 7 and the stored STROBE bit are both 0, ACK (bit 6) is cleared when it was set. Otherwise both ACK and bit 7 are set. When either bit 7 or the stored STROBE bit is 1, the status read leaves the status unchanged.
- R9: A data read returns the input latch when control bit 5 (direction) is 1 and the output latch when it is 0. A cycle with `in_load` high loads `in_data` into the input latch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_wr | input | 1 | Host write strobe, one cycle per access |
| bus_rd | input | 1 | Host read strobe, one cycle per access; ignored when bus_wr is high |
| bus_addr | input | ADDR_W | Register offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the offset on bus_addr, valid in the read cycle |
| in_load | input | 1 | Loads in_data into the input latch |
| in_data | input | 8 | Byte arriving from the peripheral |
| byte_out | output | 8 | Last byte emitted by a strobe edge |
| byte_sent | output | 1 | One-clock pulse when byte_out is emitted |
| irq | output | 1 | Interrupt request, registered copy of the pending flag |

## Verification
The bench builds the block with ADDR_W at its default of 3, so all eight offsets can be reached. This covers the five unmapped offsets that must read 0xFF and ignore writes. With that width the bench walks the complete handshake: it arms the interrupt from a strobe release, clears it with a status read, and steps the acknowledge bit through cleared and re-set states. Repeated strobe-high writes and a direction switch cover the cases where no byte may be sent and where the input latch is returned.

// File: rtl/prn_pkg.sv
package prn_pkg;

  // register offsets
  localparam int OFS_DATA = 0;
  localparam int OFS_STAT = 1;
  localparam int OFS_CTRL = 2;

  // status bit positions
  localparam int ST_NBUSY = 7;
  localparam int ST_ACK   = 6;

  // control bit positions
  localparam int CT_DIR    = 5;
  localparam int CT_IEN    = 4;
  localparam int CT_SEL    = 3;
  localparam int CT_NINIT  = 2;
  localparam int CT_STROBE = 0;

  localparam logic [7:0] CTRL_FORCED  = 8'hC0;
  localparam logic [7:0] STAT_RST     = 8'hD9;
  localparam logic [7:0] STAT_INIT    = 8'hD8;
  localparam logic [7:0] CTRL_RST     = 8'hCC;
  localparam logic [7:0] LATCH_RST    = 8'hFF;
  localparam logic [7:0] UNMAPPED_VAL = 8'hFF;

  typedef struct packed {
    logic init_load;
    logic busy_clear;
    logic send;
    logic arm;
  } ctrl_evt_t;

  function automatic logic [7:0] ctrl_merge(input logic [7:0] w);
    return w | CTRL_FORCED;
  endfunction

  // effects of a control write given the merged new value and the stored value
  function automatic ctrl_evt_t ctrl_classify(input logic [7:0] nv,
                                              input logic [7:0] ov);
    ctrl_evt_t e;
    e = '0;
    if (!nv[CT_NINIT]) begin
      e.init_load = 1'b1;
    end else if (nv[CT_SEL]) begin
      if (nv[CT_STROBE]) begin
        e.busy_clear = 1'b1;
        e.send       = !ov[CT_STROBE];
      end else begin
        e.arm = ov[CT_IEN];
      end
    end
    return e;
  endfunction

  // status after a status read
  function automatic logic [7:0] ack_step(input logic [7:0] s, input logic strobe);
    logic [7:0] n;
    n = s;
    if (!s[ST_NBUSY] && !strobe) begin
      if (s[ST_ACK]) begin
        n[ST_ACK] = 1'b0;
      end else begin
        n[ST_ACK]   = 1'b1;
        n[ST_NBUSY] = 1'b1;
      end
    end
    return n;
  endfunction

endpackage

// File: rtl/prn_ctrl_path.sv
module prn_ctrl_path
  import prn_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       data_wr,
  input  logic       ctrl_wr,
  input  logic [7:0] wdata,
  input  logic       in_load,
  input  logic [7:0] in_data,
  output logic [7:0] ctrl_q,
  output logic [7:0] dataw_q,
  output logic [7:0] datar_q,
  output logic [7:0] byte_out,
  output logic       byte_sent,
  output logic       ev_init_load,
  output logic       ev_busy_clear,
  output logic       ev_arm
);

  logic [7:0] ctrl_new;
  ctrl_evt_t  evt;
  logic       ev_send;

  always_comb begin
    ctrl_new = ctrl_merge(wdata);
    evt      = ctrl_wr ? ctrl_classify(ctrl_new, ctrl_q) : '0;
  end

  assign ev_init_load  = evt.init_load;
  assign ev_busy_clear = evt.busy_clear;
  assign ev_arm        = evt.arm;
  assign ev_send       = evt.send;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q    <= CTRL_RST;
      dataw_q   <= LATCH_RST;
      datar_q   <= LATCH_RST;
      byte_out  <= LATCH_RST;
      byte_sent <= 1'b0;
    end else begin
      byte_sent <= ev_send;
      if (ev_send) byte_out <= dataw_q;
      if (ctrl_wr) ctrl_q <= ctrl_new;
      if (data_wr) dataw_q <= wdata;
      if (in_load) datar_q <= in_data;
    end
  end

  // R5: a byte is sent at most once per strobe edge
  p_sent_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
    byte_sent |=> !byte_sent);

  // R5: the emitted byte is the output latch from the write cycle
  p_sent_value_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ev_send |=> (byte_sent && byte_out == $past(dataw_q)));

  // R3: the stored control always has its two top bits set
  p_ctrl_top_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_wr |=> (ctrl_q[7:6] == 2'b11 && ctrl_q[5:0] == $past(wdata[5:0])));

endmodule

// File: rtl/prn_status_path.sv
module prn_status_path
  import prn_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       data_wr,
  input  logic       ctrl_wr,
  input  logic       stat_rd,
  input  logic       ev_init_load,
  input  logic       ev_busy_clear,
  input  logic       ev_arm,
  input  logic       strobe_q,
  output logic [7:0] status_q,
  output logic       irq
);

  logic       pend_q;
  logic       pend_nxt;
  logic [7:0] status_nxt;
  logic       irq_eval;

  always_comb begin
    pend_nxt = pend_q;
    if (ev_arm)  pend_nxt = 1'b1;
    if (stat_rd) pend_nxt = 1'b0;

    status_nxt = status_q;
    if (ev_init_load) begin
      status_nxt = STAT_INIT;
    end else if (ev_busy_clear) begin
      status_nxt[ST_NBUSY] = 1'b0;
    end else if (stat_rd) begin
      status_nxt = ack_step(status_q, strobe_q);
    end

    irq_eval = data_wr | ctrl_wr | stat_rd;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status_q <= STAT_RST;
      pend_q   <= 1'b0;
      irq      <= 1'b0;
    end else begin
      status_q <= status_nxt;
      pend_q   <= pend_nxt;
      if (irq_eval) irq <= pend_nxt;
    end
  end

  // R4: an init-low control write loads the fixed status pattern
  p_init_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ev_init_load |=> (status_q == STAT_INIT));

  // R5: strobe high with select clears the busy-complement bit
  p_busy_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ev_busy_clear |=> !status_q[ST_NBUSY]);

  // R6: arming raises irq on the next clock
  p_irq_arm_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ev_arm |=> irq);

  // R7: a status read drops irq
  p_stat_rd_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
    stat_rd |=> !irq);

  // R8: acknowledge is withdrawn when busy-complement and strobe are low
  p_ack_fall_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd && !status_q[ST_NBUSY] && !strobe_q && status_q[ST_ACK])
      |=> (!status_q[ST_ACK] && !status_q[ST_NBUSY]));

  // R8: otherwise a status read leaves status alone when busy-complement is set
  p_ack_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd && status_q[ST_NBUSY]) |=> $stable(status_q));

endmodule

// File: rtl/prn_rd_mux.sv
module prn_rd_mux
  import prn_pkg::*;
#(
  parameter int ADDR_W = 3
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        ctrl_q,
  input  logic [7:0]        status_q,
  input  logic [7:0]        dataw_q,
  input  logic [7:0]        datar_q,
  output logic [7:0]        rdata
);

  always_comb begin
    if (addr == ADDR_W'(OFS_DATA)) begin
      rdata = ctrl_q[CT_DIR] ? datar_q : dataw_q;
    end else if (addr == ADDR_W'(OFS_STAT)) begin
      rdata = status_q;
    end else if (addr == ADDR_W'(OFS_CTRL)) begin
      rdata = ctrl_q;
    end else begin
      rdata = UNMAPPED_VAL;
    end
  end

endmodule

// File: rtl/prn_port_regs.sv
module prn_port_regs
  import prn_pkg::*;
#(
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  input  logic              in_load,
  input  logic [7:0]        in_data,
  output logic [7:0]        byte_out,
  output logic              byte_sent,
  output logic              irq
);

  localparam int NUM_OFS = 1 << ADDR_W;

  logic       data_wr, ctrl_wr, stat_rd, rd_en;
  logic [7:0] ctrl_q, status_q, dataw_q, datar_q;
  logic       ev_init_load, ev_busy_clear, ev_arm;

  assign rd_en   = bus_rd & ~bus_wr;
  assign data_wr = bus_wr & (bus_addr == ADDR_W'(OFS_DATA));
  assign ctrl_wr = bus_wr & (bus_addr == ADDR_W'(OFS_CTRL));
  assign stat_rd = rd_en  & (bus_addr == ADDR_W'(OFS_STAT));

  prn_ctrl_path u_ctrl (
    .clk           (clk),
    .rst_n         (rst_n),
    .data_wr       (data_wr),
    .ctrl_wr       (ctrl_wr),
    .wdata         (bus_wdata),
    .in_load       (in_load),
    .in_data       (in_data),
    .ctrl_q        (ctrl_q),
    .dataw_q       (dataw_q),
    .datar_q       (datar_q),
    .byte_out      (byte_out),
    .byte_sent     (byte_sent),
    .ev_init_load  (ev_init_load),
    .ev_busy_clear (ev_busy_clear),
    .ev_arm        (ev_arm)
  );

  prn_status_path u_stat (
    .clk           (clk),
    .rst_n         (rst_n),
    .data_wr       (data_wr),
    .ctrl_wr       (ctrl_wr),
    .stat_rd       (stat_rd),
    .ev_init_load  (ev_init_load),
    .ev_busy_clear (ev_busy_clear),
    .ev_arm        (ev_arm),
    .strobe_q      (ctrl_q[CT_STROBE]),
    .status_q      (status_q),
    .irq           (irq)
  );

  prn_rd_mux #(.ADDR_W(ADDR_W)) u_mux (
    .addr     (bus_addr),
    .ctrl_q   (ctrl_q),
    .status_q (status_q),
    .dataw_q  (dataw_q),
    .datar_q  (datar_q),
    .rdata    (bus_rdata)
  );

  // R2: offsets beyond the register set read back as all ones
  p_unmapped_ff_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(bus_addr) > OFS_CTRL && int'(bus_addr) < NUM_OFS) |-> (bus_rdata == UNMAPPED_VAL));

  // R2: a write to an unmapped or status offset leaves control and status alone
  p_dead_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && int'(bus_addr) != OFS_DATA && int'(bus_addr) != OFS_CTRL)
      |=> ($stable(ctrl_q) && $stable(status_q)));

endmodule

// File: tb/sim_prn_port_regs.sv
module sim_prn_port_regs;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_wr = 1'b0, bus_rd = 1'b0, in_load = 1'b0;
  logic [2:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0, in_data = '0;
  logic [7:0] bus_rdata, byte_out;
  logic       byte_sent, irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [7:0] rd_exp_q[$];
  string      rd_tag_q[$];
  logic [7:0] tx_exp_q[$];
  string      tx_tag_q[$];

  always #10 clk = ~clk; // 50 MHz

  prn_port_regs #(.ADDR_W(3)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .in_load(in_load), .in_data(in_data), .byte_out(byte_out),
    .byte_sent(byte_sent), .irq(irq)
  );

  function automatic void compare(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endfunction

  // monitor: pops expected items as the design produces results
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (bus_rd && !bus_wr) begin
        if (rd_exp_q.size() == 0) compare("read-unexpected", bus_rdata, 8'hxx);
        else compare(rd_tag_q.pop_front(), bus_rdata, rd_exp_q.pop_front());
      end
      if (byte_sent) begin
        if (tx_exp_q.size() == 0) begin
          checks++; errors++;
          $display("FAIL R5 unexpected byte actual=%02h expected=none", byte_out);
        end else compare(tx_tag_q.pop_front(), byte_out, tx_exp_q.pop_front());
      end
    end
  end

  task automatic bus_write(input logic [2:0] a, input logic [7:0] d);
    @(posedge clk); #1;
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1;
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [2:0] a, input logic [7:0] exp, input string tag);
    rd_exp_q.push_back(exp);
    rd_tag_q.push_back(tag);
    @(posedge clk); #1;
    bus_rd = 1'b1; bus_addr = a;
    @(posedge clk); #1;
    bus_rd = 1'b0;
  endtask

  task automatic expect_byte(input logic [7:0] b, input string tag);
    tx_exp_q.push_back(b);
    tx_tag_q.push_back(tag);
  endtask

  task automatic check_irq(input logic exp, input string tag);
    @(negedge clk);
    compare(tag, {7'd0, irq}, {7'd0, exp});
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1 reset state
    check_irq(1'b0, "R1 irq");
    bus_read(3'd0, 8'hFF, "R1 data");
    bus_read(3'd1, 8'hD9, "R1 status");
    bus_read(3'd2, 8'hCC, "R1 control");
    bus_read(3'd1, 8'hD9, "R8 status held while busy-complement set");

    // R2 unmapped offsets
    for (int a = 3; a < 8; a++) bus_read(3'(a), 8'hFF, "R2 unmapped read");

    // R9 / R3 data and control
    bus_write(3'd0, 8'hA5);
    bus_read(3'd0, 8'hA5, "R9 output latch");
    bus_write(3'd2, 8'h08);
    bus_read(3'd2, 8'hC8, "R3 control merge");
    bus_read(3'd1, 8'hD8, "R4 init load");
    bus_read(3'd1, 8'hD8, "R8 no step while busy-complement set");

    // R6 negative: enable was not stored before
    bus_write(3'd2, 8'h1C);
    check_irq(1'b0, "R6 no arm without stored enable");

    // R5 strobe edge
    expect_byte(8'hA5, "R5 byte value");
    bus_write(3'd2, 8'h1D);
    bus_read(3'd1, 8'h58, "R5 busy cleared");
    bus_write(3'd2, 8'h1D); // no edge, no byte
    bus_read(3'd2, 8'hDD, "R3 control readback");

    // R6 arm
    bus_write(3'd2, 8'h1C);
    check_irq(1'b1, "R6 irq armed");

    // R7 / R8 status read sequence
    bus_read(3'd1, 8'h58, "R7 status value before step");
    check_irq(1'b0, "R7 irq cleared");
    bus_read(3'd1, 8'h18, "R8 ack cleared");
    bus_read(3'd1, 8'hD8, "R8 ack and busy set");
    bus_read(3'd1, 8'hD8, "R8 held");

    // R9 direction and input latch
    @(posedge clk); #1 in_load = 1'b1; in_data = 8'h3C;
    @(posedge clk); #1 in_load = 1'b0;
    bus_read(3'd0, 8'hA5, "R9 direction out");
    bus_write(3'd2, 8'h04);
    bus_write(3'd2, 8'h24);
    check_irq(1'b0, "R6 no arm without select");
    bus_read(3'd0, 8'h3C, "R9 input latch");

    // R2 ignored writes
    bus_write(3'd1, 8'h00);
    bus_write(3'd5, 8'h00);
    bus_read(3'd1, 8'hD8, "R2 status write ignored");
    bus_read(3'd2, 8'hE4, "R2 control untouched");
    bus_read(3'd5, 8'hFF, "R2 unmapped after write");

    // R5 second byte pattern
    bus_write(3'd0, 8'h77);
    bus_write(3'd2, 8'h0C);
    expect_byte(8'h77, "R5 second byte");
    bus_write(3'd2, 8'h0D);
    bus_read(3'd1, 8'h58, "R5 busy cleared again");
    bus_read(3'd0, 8'h77, "R9 output latch after direction back");

    // R4 init mid stream
    bus_write(3'd2, 8'h00);
    bus_read(3'd1, 8'hD8, "R4 init reload");
    bus_read(3'd2, 8'hC0, "R3 control all low");

    repeat (3) @(negedge clk);
    checks++;
    if (rd_exp_q.size() != 0 || tx_exp_q.size() != 0) begin
      errors++;
      $display("FAIL R5 queues not drained actual=%0d expected=0",
               rd_exp_q.size() + tx_exp_q.size());
    end
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule